// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the word address for each beat of a four-beat burst in a synchronous pipelined SRAM. A load strobe captures a starting word address. The first beat presents that address unchanged. Each later clock edge with the active-low advance input low moves to the next address of the burst. The two least-significant address bits follow either a linear wrapping order or an interleaved (XOR) order, chosen by a static order-select input. The upper address bits stay as loaded for the whole burst, and the burst wraps inside its four-word block.

The sequencer is a two-state machine with a beat counter. `ST_IDLE` is the state after reset, before any address has been loaded. `ST_RUN` means a burst address is held. The transitions are: *load* (`ST_IDLE` to `ST_RUN`, capture the address, beat index cleared); *reload* (`ST_RUN` to `ST_RUN` on a load, which restarts the burst and takes priority over advance); *step* (`ST_RUN` to `ST_RUN` with advance low, beat index plus one modulo four); *hold* (`ST_RUN` to `ST_RUN` with advance high, nothing changes); *wait* (`ST_IDLE` to `ST_IDLE` when there is no load, and advance is ignored).

Top module: `burst_seq_top`

## Requirements
- R1: After reset, `cur_addr` is 0 and `beat_idx` is 0.
- R2: On the edge after `load` is high, `cur_addr` equals the `start_addr` captured at that edge and `beat_idx` is 0, in both orders.
- R3: In `ST_RUN`, with `load` low and `adv_n` low at an edge, `beat_idx` becomes the previous value plus 1 modulo 4 (3 goes to 0).
- R4: With `load` low and `adv_n` high at an edge, `beat_idx` and `cur_addr` keep their values.
- R5: With `order_il` = 0 (linear), `cur_addr[1:0]` = (loaded low bits + `beat_idx`) mod 4, so a start of 2 gives 2,3,0,1.
- R6: With `order_il` = 1 (interleaved), `cur_addr[1:0]` = loaded low bits XOR `beat_idx`, so a start of 1 gives 1,0,3,2.
- R7: `cur_addr[17:2]` always equals the upper bits of the last loaded address; a wrap never carries into them.
- R8: When `load` and `adv_n` low arrive in the same cycle, the load wins and `beat_idx` becomes 0.
- R9: In `ST_IDLE`, before any load, `adv_n` low has no effect: `beat_idx` and `cur_addr` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Address strobe; captures `start_addr` and restarts the burst |
| start_addr | input | ADDR_W (18) | Starting word address |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_il | input | 1 | Static order select: 1 interleaved, 0 linear |
| cur_addr | output | ADDR_W (18) | Word address of the current beat |
| beat_idx | output | BEAT_W (2) | Beat index, 0 to 3 |

## Verification
The hardest case to reach from the ports is a wrap past beat 3 with a hold in the middle and upper address bits that are all ones, because a carry out of the low bits would only show up with that pattern. The bench sweeps every start offset in both orders with several upper-bit patterns. Each burst is advanced past its fourth beat, with one held cycle inside it, and each burst is restarted by a load that arrives together with an advance. Before the first load it also drives advance pulses, so the idle state can be seen to ignore them.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/burst_fsm.sv
module burst_fsm #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    output logic [BEAT_W-1:0] beat
);
    import burst_seq_pkg::*;

    seq_state_t        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_RUN;
                    beat_d  = '0;
                end
            end
            ST_RUN: begin
                if (load) begin
                    beat_d = '0;
                end else if (!adv_n) begin
                    beat_d = BEAT_W'(beat_q + 1'b1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    assign beat = beat_q;

    // R3: a step moves the beat index up by one, modulo the burst length
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !load && !adv_n) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));
    // R4: advance high holds the beat index
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> $stable(beat_q));
    // R8: a load clears the beat index even with advance low
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> beat_q == '0);
    // R9: the idle state keeps the beat index at zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> beat_q == '0);
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] base
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
        end else if (load) begin
            base <= start_addr;
        end
    end
endmodule

// File: rtl/burst_order_unit.sv
module burst_order_unit #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_il,
    output logic [ADDR_W-1:0] addr
);
    logic [BEAT_W-1:0] low_lin, low_il, low_sel;

    always_comb begin
        low_lin = BEAT_W'(base[BEAT_W-1:0] + beat);
        low_il  = base[BEAT_W-1:0] ^ beat;
        low_sel = order_il ? low_il : low_lin;
    end

    assign addr = {base[ADDR_W-1:BEAT_W], low_sel};
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
    parameter int ADDR_W    = 18,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic                         adv_n,
    input  logic                         order_il,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic [$clog2(BURST_LEN)-1:0] beat_idx
);
    localparam int BEAT_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;

    burst_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv_n (adv_n),
        .beat  (beat)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .base       (base)
    );

    burst_order_unit #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_order (
        .base     (base),
        .beat     (beat),
        .order_il (order_il),
        .addr     (addr_w)
    );

    logic [ADDR_W-1:0] addr_w;

    assign cur_addr = addr_w;
    assign beat_idx = beat;

    // R2: the first beat after a load presents the strobed address
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_addr == $past(start_addr));
    // R7: without a load the upper address bits never move
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));
    // R5 and R6: beat 0 always shows the loaded low bits, whatever the order
    a_r5_r6_beat0: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $stable(order_il)) |=> cur_addr[BEAT_W-1:0] == $past(start_addr[BEAT_W-1:0]));
endmodule

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          adv_n = 1'b1;
    logic          order_il = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [1:0]    beat_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_run = 1'b0;

    always #10 clk = ~clk;

    burst_seq_top dut (
        .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
        .adv_n(adv_n), .order_il(order_il), .cur_addr(cur_addr), .beat_idx(beat_idx)
    );

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_il ? (m_base[1:0] ^ m_beat) : 2'((m_base[1:0] + m_beat) % 4);
        return {m_base[AW-1:2], lo};
    endfunction

    // Called at a falling edge: drive, pass one rising edge, update model, check.
    task automatic cycle(input bit ld, input logic [AW-1:0] sa, input bit an, input string tag);
        load = ld; start_addr = sa; adv_n = an;
        @(posedge clk);
        if (ld) begin
            m_base = sa; m_beat = 2'd0; m_run = 1'b1;
        end else if (m_run && !an) begin
            m_beat = 2'(m_beat + 1);
        end
        @(negedge clk);
        check({tag, " beat"}, {16'd0, beat_idx}, {16'd0, m_beat});
        check({tag, (order_il ? " R6 addr" : " R5 addr")}, cur_addr, exp_addr());
        check({tag, " R7 upper"}, {2'b0, cur_addr[AW-1:2]}, {2'b0, m_base[AW-1:2]});
    endtask

    initial begin
        logic [AW-1:0] uppers [3];
        uppers[0] = '0;
        uppers[1] = {16'hFFFF, 2'b00};
        uppers[2] = {16'h5A3C, 2'b00};
        @(negedge clk);
        @(negedge clk);
        check("R1 reset addr", cur_addr, '0);
        check("R1 reset beat", {16'd0, beat_idx}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) cycle(1'b0, 18'h3FFFF, 1'b0, "R9 idle");
        for (int o = 0; o < 2; o++) begin
            order_il = o[0];
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    cycle(1'b1, uppers[u] | AW'(s), 1'b1, "R2 load");
                    for (int k = 0; k < 7; k++)
                        cycle(1'b0, ~(uppers[u] | AW'(s)), (k == 2), (k == 2) ? "R4 hold" : "R3 step");
                    cycle(1'b1, uppers[u] ^ AW'(s), 1'b0, "R8 load+adv");
                    cycle(1'b0, '0, 1'b0, "R3 after reload");
                end
            end
        end
        // Directed sequences from the requirement examples
        order_il = 1'b0;
        cycle(1'b1, 18'd2, 1'b1, "R2 lin2");
        cycle(1'b0, '0, 1'b0, "R5 lin2 b1");
        check("R5 lin2 seq", {16'd0, cur_addr[1:0]}, 18'd3);
        order_il = 1'b1;
        cycle(1'b1, 18'd1, 1'b1, "R2 il1");
        cycle(1'b0, '0, 1'b0, "R6 il1 b1");
        check("R6 il1 seq", {16'd0, cur_addr[1:0]}, 18'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule